// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block moves received frames from a byte-wide stream into host memory through a circular ring of eight-byte descriptors. When a frame begins, the engine fetches the status word of the current descriptor. If the host has marked that entry as available, it also fetches the buffer address, packs the incoming bytes into 32-bit little-endian words and writes them to the buffer. It then overwrites the status word with the stored length, the error flags and a completion mark, and moves to the next descriptor.

The host prepares the ring through a small register port: a base address and an entry count. It arms each entry by writing a buffer address into the first word and a status word with bit 31 set and the buffer room minus one in bits 10:0 into the second word. When the current entry is not available, the frame is swallowed rather than written anywhere. A dedicated interrupt pulse reports this, and the engine stays on the same entry so that it is used once the host re-arms it.

The controller is a state machine with these states and transitions. ST_IDLE goes to ST_FLAG_REQ when a stream byte is offered. ST_FLAG_REQ goes to ST_FLAG_WAIT when the read is granted. ST_FLAG_WAIT goes to ST_ADDR_REQ if bit 31 is set, or to ST_DROP if it is clear, on read data. ST_ADDR_REQ goes to ST_ADDR_WAIT on grant. ST_ADDR_WAIT goes to ST_RECV on read data. ST_RECV goes to ST_DATA_WR when a word is complete, when the room is reached, or when the last byte is stored; it goes to ST_DESC_WR when the last byte falls beyond the room. ST_DATA_WR goes to ST_DESC_WR on grant after the last byte, otherwise back to ST_RECV. ST_DESC_WR goes to ST_IDLE on grant. ST_DROP goes to ST_IDLE when the last byte is taken.

Top module: `rxr_ring_writer`

## Requirements
- R1: A register write with `cfg_sel`=0 sets the ring base, with bits 2:0 of the data ignored. A write with `cfg_sel`=1 sets the entry count minus one from data bits 31:16. Any register write sends the engine back to entry 0. After reset the base is 0 and the ring has one entry.
- R2: For each frame the engine first reads the status word at descriptor address + 4. Only if that word marks the entry available does it read the buffer address at descriptor address + 0. No descriptor read happens without a waiting frame.
- R3: A descriptor is available when bit 31 of its status word is 1. Its room in bytes is status bits 10:0 plus one, and a frame of exactly that length is stored whole with no overflow mark.
- R4: Stored bytes are written as 32-bit words starting at the buffer address with bits 1:0 forced to zero. Each following word goes 4 bytes higher, byte i of the frame lands in bits 8*(i mod 4)+7:8*(i mod 4), and unused bytes of the final word are zero.
- R5: The status word is written back after the last data write is accepted. It has bit 31 = 0, bit 16 = 1, bits 10:0 = stored byte count minus one, and all other bits zero apart from the error bits.
- R6: Error sideband sampled with the last byte is written back as follows: CRC to bit 27, framing to bit 29 and overflow to bit 28. Bit 30 is set whenever any of bits 27, 28 or 29 is set.
- R7: Bytes beyond the room are accepted and discarded. The stored length equals the room, and bits 28 and 30 are set.
- R8: After a writeback the descriptor address advances by 8. After the last entry it returns to the ring base.
- R9: If the status word has bit 31 = 0, the frame is consumed with no memory write, `irq_nobuf` pulses for one cycle and the descriptor pointer does not move.
- R10: `irq_rx` pulses for one cycle in the cycle the writeback is accepted when no error bit is set. Otherwise `irq_rxerr` pulses instead. At most one interrupt output is high in any cycle.
- R11: A memory request holds its address, direction and write data until `mem_gnt`. Read data is taken on `mem_rvalid` in any later cycle, and all memory addresses are word aligned.
- R12: During and right after reset, `mem_req`, `s_ready` and all interrupt outputs are low.
- R13: `s_ready` is low whenever the engine is not receiving or discarding a frame, and never high while a memory request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | Register select: 0 ring base, 1 ring size |
| cfg_wdata | input | 32 | Register write data |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | ADDR_W | Memory byte address, word aligned |
| mem_wdata | output | 32 | Memory write data |
| mem_gnt | input | 1 | Memory accepts the request this cycle |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| s_valid | input | 1 | Stream byte valid |
| s_ready | output | 1 | Stream byte accepted |
| s_data | input | 8 | Stream byte |
| s_last | input | 1 | Final byte of the frame |
| s_err_crc | input | 1 | CRC error, valid with last |
| s_err_frame | input | 1 | Framing error, valid with last |
| s_err_ovf | input | 1 | Upstream overflow, valid with last |
| irq_rx | output | 1 | Frame stored without error |
| irq_rxerr | output | 1 | Frame stored with error |
| irq_nobuf | output | 1 | Frame dropped, no available descriptor |

## Verification
A stale ring index shows up at the very next frame as a status read at the wrong address, well before any data moves. A wrong byte lane or a missed flush corrupts the first buffer write of the frame. A packer count that drifts shows only in the writeback length and overflow bits, one write after the data. A state machine that takes the wrong branch on the available bit shows either as a buffer write where none is allowed or as a missing one, within a few cycles of the status read.

// File: rtl/rxr_pkg.sv
package rxr_pkg;

    localparam int unsigned WORD_W     = 32;
    localparam int unsigned DESC_BYTES = 8;
    localparam int unsigned FLAG_OFS_B = 4;

    localparam int unsigned BIT_AVAIL  = 31;
    localparam int unsigned BIT_ERRSUM = 30;
    localparam int unsigned BIT_FRAME  = 29;
    localparam int unsigned BIT_OVF    = 28;
    localparam int unsigned BIT_CRC    = 27;
    localparam int unsigned BIT_DONE   = 16;
    localparam int unsigned SIZE_LSB   = 16;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_FLAG_REQ,
        ST_FLAG_WAIT,
        ST_ADDR_REQ,
        ST_ADDR_WAIT,
        ST_RECV,
        ST_DATA_WR,
        ST_DESC_WR,
        ST_DROP
    } rxr_state_e;

    typedef struct packed {
        logic crc;
        logic frame;
        logic ovf;
    } rxr_err_t;

endpackage

// File: rtl/rxr_cfg.sv
module rxr_cfg
    import rxr_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned IDX_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_sel,
    input  logic [31:0]       cfg_wdata,
    output logic [ADDR_W-1:0] ring_base,
    output logic [IDX_W-1:0]  ring_last,
    output logic              restart
);

    localparam int unsigned ALIGN_B = $clog2(DESC_BYTES);

    logic [ALIGN_B-1:0] unused_low;
    assign unused_low = cfg_wdata[ALIGN_B-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ring_base <= '0;
            ring_last <= '0;
            restart   <= 1'b0;
        end else begin
            restart <= cfg_we;
            if (cfg_we) begin
                if (!cfg_sel) begin
                    ring_base <= {cfg_wdata[ADDR_W-1:ALIGN_B], {ALIGN_B{1'b0}}};
                end else begin
                    ring_last <= cfg_wdata[SIZE_LSB +: IDX_W];
                end
            end
        end
    end

endmodule

// File: rtl/rxr_ptr.sv
module rxr_ptr
    import rxr_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned IDX_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] ring_base,
    input  logic [IDX_W-1:0]  ring_last,
    input  logic              restart,
    input  logic              advance,
    output logic [ADDR_W-1:0] desc_addr
);

    localparam int unsigned SHIFT = $clog2(DESC_BYTES);

    logic [IDX_W-1:0] idx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx <= '0;
        end else if (restart) begin
            idx <= '0;
        end else if (advance) begin
            idx <= (idx == ring_last) ? '0 : idx + 1'b1;
        end
    end

    assign desc_addr = ring_base + (ADDR_W'(idx) << SHIFT);

endmodule

// File: rtl/rxr_packer.sv
module rxr_packer
    import rxr_pkg::*;
#(
    parameter int unsigned LEN_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] room_m1,
    input  logic             take,
    input  logic [7:0]       byte_in,
    input  logic             clear,
    output logic [31:0]      word,
    output logic [LEN_W:0]   count,
    output logic             trunc,
    output logic             store_now,
    output logic             flush_now
);

    localparam int unsigned LANES  = WORD_W / 8;
    localparam int unsigned LANE_W = $clog2(LANES);

    logic [LEN_W:0]    room;
    logic [LANE_W-1:0] lane;
    logic [7:0]        lane_q [LANES];

    assign store_now = take && (count != room);
    assign flush_now = store_now &&
                       ((lane == LANE_W'(LANES - 1)) || ((count + 1'b1) == room));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            room  <= '0;
            count <= '0;
            lane  <= '0;
            trunc <= 1'b0;
        end else if (start) begin
            room  <= {1'b0, room_m1} + 1'b1;
            count <= '0;
            lane  <= '0;
            trunc <= 1'b0;
        end else begin
            if (clear) begin
                lane <= '0;
            end
            if (take) begin
                if (store_now) begin
                    lane  <= lane + 1'b1;
                    count <= count + 1'b1;
                end else begin
                    trunc <= 1'b1;
                end
            end
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lane_q[g] <= '0;
            end else if (start || clear) begin
                lane_q[g] <= '0;
            end else if (store_now && (lane == LANE_W'(g))) begin
                lane_q[g] <= byte_in;
            end
        end
        assign word[g*8 +: 8] = lane_q[g];
    end

endmodule

// File: rtl/rxr_ctrl.sv
module rxr_ctrl
    import rxr_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned LEN_W  = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s_valid,
    input  logic              s_last,
    input  logic              s_err_crc,
    input  logic              s_err_frame,
    input  logic              s_err_ovf,
    output logic              s_ready,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_gnt,
    input  logic              mem_rvalid,
    input  logic [31:0]       mem_rdata,
    input  logic [ADDR_W-1:0] desc_addr,
    output logic              advance,
    output logic              pk_start,
    output logic [LEN_W-1:0]  pk_room_m1,
    output logic              pk_take,
    output logic              pk_clear,
    input  logic [31:0]       pk_word,
    input  logic [LEN_W:0]    pk_count,
    input  logic              pk_trunc,
    input  logic              pk_store_now,
    input  logic              pk_flush_now,
    output logic              irq_rx,
    output logic              irq_rxerr,
    output logic              irq_nobuf
);

    localparam logic [ADDR_W-1:0] FLAG_OFS  = ADDR_W'(FLAG_OFS_B);
    localparam logic [ADDR_W-1:0] WORD_STEP = ADDR_W'(WORD_W / 8);

    rxr_state_e        state, state_nx;
    logic [ADDR_W-1:0] buf_ptr;
    logic              last_q;
    rxr_err_t          err_q;
    logic              any_err;
    logic [31:0]       status;
    logic [1:0]        unused_rd;

    assign unused_rd = mem_rdata[1:0];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:      if (s_valid) state_nx = ST_FLAG_REQ;
            ST_FLAG_REQ:  if (mem_gnt) state_nx = ST_FLAG_WAIT;
            ST_FLAG_WAIT: if (mem_rvalid) state_nx = mem_rdata[BIT_AVAIL] ? ST_ADDR_REQ : ST_DROP;
            ST_ADDR_REQ:  if (mem_gnt) state_nx = ST_ADDR_WAIT;
            ST_ADDR_WAIT: if (mem_rvalid) state_nx = ST_RECV;
            ST_RECV: begin
                if (s_valid) begin
                    if (s_last) begin
                        state_nx = pk_store_now ? ST_DATA_WR : ST_DESC_WR;
                    end else if (pk_flush_now) begin
                        state_nx = ST_DATA_WR;
                    end
                end
            end
            ST_DATA_WR:   if (mem_gnt) state_nx = last_q ? ST_DESC_WR : ST_RECV;
            ST_DESC_WR:   if (mem_gnt) state_nx = ST_IDLE;
            ST_DROP:      if (s_valid && s_last) state_nx = ST_IDLE;
            default:      state_nx = ST_IDLE;
        endcase
    end

    // frame context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_ptr <= '0;
            last_q  <= 1'b0;
            err_q   <= '0;
        end else begin
            if (state == ST_FLAG_WAIT && mem_rvalid) begin
                last_q <= 1'b0;
                err_q  <= '0;
            end
            if (state == ST_ADDR_WAIT && mem_rvalid) begin
                buf_ptr <= {mem_rdata[ADDR_W-1:2], 2'b00};
            end
            if (state == ST_DATA_WR && mem_gnt) begin
                buf_ptr <= buf_ptr + WORD_STEP;
            end
            if (state == ST_RECV && s_valid && s_last) begin
                last_q <= 1'b1;
                err_q  <= '{crc: s_err_crc, frame: s_err_frame, ovf: s_err_ovf};
            end
        end
    end

    assign any_err = err_q.crc | err_q.frame | err_q.ovf | pk_trunc;

    always_comb begin
        status               = '0;
        status[BIT_DONE]     = 1'b1;
        status[LEN_W-1:0]    = LEN_W'(pk_count - 1'b1);
        status[BIT_CRC]      = err_q.crc;
        status[BIT_FRAME]    = err_q.frame;
        status[BIT_OVF]      = err_q.ovf | pk_trunc;
        status[BIT_ERRSUM]   = any_err;
    end

    // outputs
    always_comb begin
        s_ready    = 1'b0;
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        mem_addr   = '0;
        mem_wdata  = '0;
        advance    = 1'b0;
        pk_start   = 1'b0;
        pk_room_m1 = mem_rdata[LEN_W-1:0];
        pk_take    = 1'b0;
        pk_clear   = 1'b0;
        irq_rx     = 1'b0;
        irq_rxerr  = 1'b0;
        irq_nobuf  = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_FLAG_REQ: begin
                mem_req  = 1'b1;
                mem_addr = desc_addr + FLAG_OFS;
            end
            ST_FLAG_WAIT: begin
                pk_start  = mem_rvalid;
                irq_nobuf = mem_rvalid && !mem_rdata[BIT_AVAIL];
            end
            ST_ADDR_REQ: begin
                mem_req  = 1'b1;
                mem_addr = desc_addr;
            end
            ST_ADDR_WAIT: ;
            ST_RECV: begin
                s_ready = 1'b1;
                pk_take = s_valid;
            end
            ST_DATA_WR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = buf_ptr;
                mem_wdata = pk_word;
                pk_clear  = mem_gnt;
            end
            ST_DESC_WR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = desc_addr + FLAG_OFS;
                mem_wdata = status;
                advance   = mem_gnt;
                irq_rx    = mem_gnt && !any_err;
                irq_rxerr = mem_gnt && any_err;
            end
            ST_DROP: begin
                s_ready = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/rxr_ring_writer.sv
module rxr_ring_writer
    import rxr_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned IDX_W  = 16,
    parameter int unsigned LEN_W  = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_sel,
    input  logic [31:0]       cfg_wdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_gnt,
    input  logic              mem_rvalid,
    input  logic [31:0]       mem_rdata,
    input  logic              s_valid,
    output logic              s_ready,
    input  logic [7:0]        s_data,
    input  logic              s_last,
    input  logic              s_err_crc,
    input  logic              s_err_frame,
    input  logic              s_err_ovf,
    output logic              irq_rx,
    output logic              irq_rxerr,
    output logic              irq_nobuf
);

    logic [ADDR_W-1:0] ring_base;
    logic [IDX_W-1:0]  ring_last;
    logic              restart;
    logic              advance;
    logic [ADDR_W-1:0] desc_addr;
    logic              pk_start;
    logic [LEN_W-1:0]  pk_room_m1;
    logic              pk_take;
    logic              pk_clear;
    logic [31:0]       pk_word;
    logic [LEN_W:0]    pk_count;
    logic              pk_trunc;
    logic              pk_store_now;
    logic              pk_flush_now;

    rxr_cfg #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .ring_base (ring_base),
        .ring_last (ring_last),
        .restart   (restart)
    );

    rxr_ptr #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .ring_base (ring_base),
        .ring_last (ring_last),
        .restart   (restart),
        .advance   (advance),
        .desc_addr (desc_addr)
    );

    rxr_packer #(.LEN_W(LEN_W)) u_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (pk_start),
        .room_m1   (pk_room_m1),
        .take      (pk_take),
        .byte_in   (s_data),
        .clear     (pk_clear),
        .word      (pk_word),
        .count     (pk_count),
        .trunc     (pk_trunc),
        .store_now (pk_store_now),
        .flush_now (pk_flush_now)
    );

    rxr_ctrl #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .s_valid      (s_valid),
        .s_last       (s_last),
        .s_err_crc    (s_err_crc),
        .s_err_frame  (s_err_frame),
        .s_err_ovf    (s_err_ovf),
        .s_ready      (s_ready),
        .mem_req      (mem_req),
        .mem_we       (mem_we),
        .mem_addr     (mem_addr),
        .mem_wdata    (mem_wdata),
        .mem_gnt      (mem_gnt),
        .mem_rvalid   (mem_rvalid),
        .mem_rdata    (mem_rdata),
        .desc_addr    (desc_addr),
        .advance      (advance),
        .pk_start     (pk_start),
        .pk_room_m1   (pk_room_m1),
        .pk_take      (pk_take),
        .pk_clear     (pk_clear),
        .pk_word      (pk_word),
        .pk_count     (pk_count),
        .pk_trunc     (pk_trunc),
        .pk_store_now (pk_store_now),
        .pk_flush_now (pk_flush_now),
        .irq_rx       (irq_rx),
        .irq_rxerr    (irq_rxerr),
        .irq_nobuf    (irq_nobuf)
    );

endmodule

// File: rtl/rxr_ring_writer_chk.sv
module rxr_ring_writer_chk #(
    parameter int unsigned ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              s_ready,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [31:0]       mem_wdata,
    input logic              mem_gnt,
    input logic              mem_rvalid,
    input logic              rd_avail,
    input logic              irq_rx,
    input logic              irq_rxerr,
    input logic              irq_nobuf
);

    assert_irq_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({irq_rx, irq_rxerr, irq_nobuf}));

    assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    assert_word_align_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[1:0] == 2'b00));

    assert_done_mark_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_rx || irq_rxerr) |-> (mem_req && mem_we && mem_gnt && !mem_wdata[31] && mem_wdata[16]));

    assert_err_summary_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_rx || irq_rxerr) && (mem_wdata[29:27] != 3'b000)) |-> mem_wdata[30]);

    assert_nobuf_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_nobuf |-> (mem_rvalid && !rd_avail));

    assert_nobuf_no_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_nobuf |=> !mem_req);

    assert_ready_vs_req_R13: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready |-> !mem_req);

endmodule

bind rxr_ring_writer rxr_ring_writer_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .s_ready    (s_ready),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_gnt    (mem_gnt),
    .mem_rvalid (mem_rvalid),
    .rd_avail   (mem_rdata[31]),
    .irq_rx     (irq_rx),
    .irq_rxerr  (irq_rxerr),
    .irq_nobuf  (irq_nobuf)
);

// File: tb/rxr_ring_writer_tb.sv
module rxr_ring_writer_tb;

    localparam int ADDR_W = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_we = 1'b0;
    logic              cfg_sel = 1'b0;
    logic [31:0]       cfg_wdata = '0;
    logic              mem_req, mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [31:0]       mem_wdata;
    logic              mem_gnt;
    logic              mem_rvalid = 1'b0;
    logic [31:0]       mem_rdata = '0;
    logic              s_valid = 1'b0;
    logic              s_ready;
    logic [7:0]        s_data = '0;
    logic              s_last = 1'b0;
    logic              s_err_crc = 1'b0, s_err_frame = 1'b0, s_err_ovf = 1'b0;
    logic              irq_rx, irq_rxerr, irq_nobuf;

    always #10 clk = ~clk;

    rxr_ring_writer u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data), .s_last(s_last),
        .s_err_crc(s_err_crc), .s_err_frame(s_err_frame), .s_err_ovf(s_err_ovf),
        .irq_rx(irq_rx), .irq_rxerr(irq_rxerr), .irq_nobuf(irq_nobuf)
    );

    int n_tests = 0;
    int n_fail  = 0;

    typedef struct {
        bit [31:0] a;
        bit [31:0] d;
        string     tag;
    } wr_t;

    bit [31:0] mem [bit [31:0]];
    wr_t       exp_wr [$];
    bit [31:0] exp_rd [$];
    int        exp_irq [$];

    bit [31:0] m_base;
    int        m_last;
    int        m_idx;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // grant pattern
    logic [3:0] lfsr = 4'b1001;
    always @(posedge clk) lfsr <= {lfsr[2:0], lfsr[3] ^ lfsr[2]};
    assign mem_gnt = mem_req & (lfsr[0] | lfsr[1]);

    // memory model
    always @(posedge clk) begin
        mem_rvalid <= 1'b0;
        if (rst_n && mem_req && mem_gnt) begin
            if (mem_we) begin
                mem[mem_addr] = mem_wdata;
            end else begin
                mem_rvalid <= 1'b1;
                mem_rdata  <= mem.exists(mem_addr) ? mem[mem_addr] : 32'h0;
            end
        end
    end

    // per-clock comparison
    logic              prev_wait = 1'b0;
    logic [ADDR_W-1:0] prev_addr;
    logic [31:0]       prev_data;
    logic              prev_we;

    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_wait) begin
                chk(mem_req && mem_addr == prev_addr && mem_wdata == prev_data && mem_we == prev_we,
                    "R11", "request held until grant", mem_addr, prev_addr);
            end
            prev_wait = mem_req && !mem_gnt;
            prev_addr = mem_addr;
            prev_data = mem_wdata;
            prev_we   = mem_we;

            if (mem_req && mem_we && mem_gnt) begin
                if (exp_wr.size() == 0) begin
                    chk(1'b0, "R9", "unexpected memory write", mem_addr, 32'h0);
                end else begin
                    wr_t e;
                    e = exp_wr.pop_front();
                    chk(mem_addr == e.a, e.tag, "write address", mem_addr, e.a);
                    chk(mem_wdata == e.d, e.tag, "write data", mem_wdata, e.d);
                end
            end
            if (mem_req && !mem_we && mem_gnt) begin
                if (exp_rd.size() == 0) begin
                    chk(1'b0, "R2", "unexpected descriptor read", mem_addr, 32'h0);
                end else begin
                    bit [31:0] ra;
                    ra = exp_rd.pop_front();
                    chk(mem_addr == ra, "R2", "descriptor read address", mem_addr, ra);
                end
            end
            if (irq_rx || irq_rxerr || irq_nobuf) begin
                int code;
                code = irq_nobuf ? 2 : (irq_rxerr ? 1 : 0);
                chk(($countones({irq_rx, irq_rxerr, irq_nobuf}) == 1), "R10", "single interrupt",
                    {29'd0, irq_rx, irq_rxerr, irq_nobuf}, 32'h0);
                if (exp_irq.size() == 0) begin
                    chk(1'b0, "R10", "unexpected interrupt", code, 32'hFFFF_FFFF);
                end else begin
                    int ec;
                    ec = exp_irq.pop_front();
                    chk(code == ec, (ec == 2) ? "R9" : "R10", "interrupt kind", code, ec);
                end
            end
        end
    end

    task automatic cfg_write(input bit sel, input bit [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        @(negedge clk);
    endtask

    task automatic arm(input int i, input bit [31:0] buf_a, input bit [10:0] room_m1);
        mem[m_base + 32'(i * 8)]     = buf_a;
        mem[m_base + 32'(i * 8) + 4] = 32'h8000_F800 | {21'd0, room_m1};
    endtask

    task automatic wait_quiet(input string req);
        int guard;
        guard = 0;
        while ((exp_wr.size() != 0 || exp_rd.size() != 0 || exp_irq.size() != 0) && guard < 3000) begin
            @(negedge clk);
            guard++;
        end
        repeat (3) @(negedge clk);
        chk(exp_wr.size() == 0 && exp_rd.size() == 0 && exp_irq.size() == 0, req,
            "frame completed", 32'(exp_wr.size() + exp_rd.size() + exp_irq.size()), 32'h0);
    endtask

    task automatic send_frame(input int fid, input int len, input bit crc, input bit fr,
                              input bit ov, input string tag);
        bit [31:0] da, fl, ba, st;
        logic [7:0] b [$];
        int room, stored;
        bit tr, anyerr;
        for (int i = 0; i < len; i++) b.push_back(8'((fid * 37 + i * 11 + 5) & 255));
        da = m_base + 32'(m_idx * 8);
        fl = mem.exists(da + 4) ? mem[da + 4] : 32'h0;
        exp_rd.push_back(da + 4);
        if (!fl[31]) begin
            exp_irq.push_back(2);
        end else begin
            exp_rd.push_back(da);
            ba     = mem[da] & 32'hFFFF_FFFC;
            room   = int'(fl[10:0]) + 1;
            stored = (len < room) ? len : room;
            tr     = len > room;
            for (int w = 0; w * 4 < stored; w++) begin
                wr_t e;
                e.d = 32'h0;
                for (int k = 0; k < 4; k++)
                    if (w * 4 + k < stored) e.d[k*8 +: 8] = b[w * 4 + k];
                e.a   = ba + 32'(w * 4);
                e.tag = "R4";
                exp_wr.push_back(e);
            end
            anyerr = crc | fr | ov | tr;
            st = 32'h0001_0000 | 32'(stored - 1);
            st[27] = crc; st[29] = fr; st[28] = ov | tr; st[30] = anyerr;
            begin
                wr_t e;
                e.a = da + 4; e.d = st; e.tag = tag;
                exp_wr.push_back(e);
            end
            exp_irq.push_back(anyerr ? 1 : 0);
            m_idx = (m_idx == m_last) ? 0 : m_idx + 1;
        end
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            s_valid     = 1'b1;
            s_data      = b[i];
            s_last      = (i == len - 1);
            s_err_crc   = (i == len - 1) & crc;
            s_err_frame = (i == len - 1) & fr;
            s_err_ovf   = (i == len - 1) & ov;
            while (!s_ready) @(negedge clk);
        end
        @(negedge clk);
        s_valid = 1'b0; s_last = 1'b0;
        s_err_crc = 1'b0; s_err_frame = 1'b0; s_err_ovf = 1'b0;
        wait_quiet(tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!mem_req && !s_ready && !irq_rx && !irq_rxerr && !irq_nobuf, "R12", "outputs in reset",
            {27'd0, mem_req, s_ready, irq_rx, irq_rxerr, irq_nobuf}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!mem_req && !s_ready && !irq_rx && !irq_rxerr && !irq_nobuf, "R12", "outputs after reset",
            {27'd0, mem_req, s_ready, irq_rx, irq_rxerr, irq_nobuf}, 32'h0);

        // ring of four entries, base with low bits that must be ignored
        cfg_write(1'b0, 32'h0000_1003);
        cfg_write(1'b1, 32'h0003_0000);
        m_base = 32'h1000; m_last = 3; m_idx = 0;
        repeat (4) @(negedge clk);
        chk(!s_ready && !mem_req, "R13", "idle without frame", {30'd0, s_ready, mem_req}, 32'h0);

        arm(0, 32'h0000_2000, 11'd2045);
        arm(1, 32'h0000_2802, 11'd2045);
        arm(2, 32'h0000_3000, 11'd5);
        arm(3, 32'h0000_3800, 11'd3);

        send_frame(1, 5, 1'b0, 1'b0, 1'b0, "R5");
        send_frame(2, 8, 1'b1, 1'b0, 1'b0, "R6");
        send_frame(3, 10, 1'b0, 1'b0, 1'b0, "R7");
        send_frame(4, 4, 1'b0, 1'b1, 1'b0, "R3");
        // pointer has wrapped to entry 0, which is no longer available
        send_frame(5, 6, 1'b0, 1'b0, 1'b0, "R9");
        arm(0, 32'h0000_4000, 11'd2045);
        send_frame(6, 7, 1'b0, 1'b0, 1'b1, "R8");
        send_frame(7, 40, 1'b0, 1'b0, 1'b0, "R9");

        // shrink to two entries: restart at entry 0
        cfg_write(1'b1, 32'h0001_0000);
        m_last = 1; m_idx = 0;
        arm(0, 32'h0000_5000, 11'd2045);
        arm(1, 32'h0000_5800, 11'd2045);
        send_frame(8, 3, 1'b0, 1'b0, 1'b0, "R1");
        send_frame(9, 64, 1'b0, 1'b0, 1'b0, "R5");
        arm(0, 32'h0000_6000, 11'd0);
        send_frame(10, 3, 1'b1, 1'b1, 1'b0, "R8");
        arm(1, 32'h0000_6800, 11'd2045);
        send_frame(11, 1, 1'b0, 1'b0, 1'b0, "R4");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule